// File: doc/BRIEF.md
# MDIO Management Master with Command Word

This block is a management-bus master that talks to external PHY devices over a two-wire management link. It generates the management clock and sends one complete Clause-22 frame per command. Each frame carries a 32-bit preamble of ones, the start and opcode fields, the PHY and register addresses, a turnaround and sixteen data bits.

Software programs it through two 32-bit words on a simple memory-mapped port. The control word at offset 0 holds the clock divider, an enable bit and a fault mechanism. The command word at offset 4 launches a transaction when it is written with its start bit set. The start bit stays set while the frame is on the wire and clears on its own when the frame ends. After a read, the same word holds the value returned by the PHY and a flag that shows whether the PHY answered during the turnaround.

The management clock runs only while a frame is in progress. The master changes its output when that clock falls and samples the line when it rises. During the turnaround and data phases of a read, the master releases the line.

Top module: `mdio_master`

## Requirements
- R1: After reset both words read as zero, `mdc` is low and `mdio_oe` is low.
- R2: Control word at offset 0: bits 15:0 divider, bit 30 enable, bit 18 fault-enable, bit 19 fault, bit 31 busy. The fault and busy bits are read-only. Bits 29:20 and 17:16 read zero. A read returns the divider, enable and fault-enable exactly as they were written.
- R3: While a frame runs, the period of `mdc` is D+1 bus clocks, where D is the divider, except that a divider of 0 acts as 1. `mdc` stays low whenever no frame is in progress.
- R4: A write frame is driven MSB first, with every one of its 64 bits driven (`mdio_oe` high): 32 ones, 01, opcode 01, PHY address, register address, turnaround 10, then the 16 data bits. `mdio_o` changes only at a falling edge of `mdc` or when a command is accepted.
- R5: A read frame uses opcode 10. The master drives the first 46 bits and holds `mdio_oe` low for the last 18 bits, which are the two turnaround bits and the data bits.
- R6: On a read, data bits are sampled from `mdio_i` at the rising edges of `mdc` for frame bits 48 to 63, MSB first, and stored into bits 15:0 of the command word. Bit 29 (acknowledge) is set exactly when `mdio_i` is low at the rising edge of frame bit 47. Each accepted command clears bit 29, and a write frame leaves it clear.
- R7: Command word at offset 4: bit 31 start/busy, bit 30 write (1) or read (0), bits 25:21 register address, bits 20:16 PHY address, bits 15:0 data. An accepted write with bit 31 set starts exactly one frame. Bit 31 of both words reads 1 from the cycle after the write until the frame ends, and then reads 0.
- R8: A write to the command word while bit 31 is set is ignored. All of its fields keep their values and no extra frame is sent.
- R9: While enable is 0, a write to the command word is ignored: the word keeps its value, no frame is sent and `mdc` stays low.
- R10: When a read ends without an acknowledge and fault-enable is 1, the fault bit is set. Writing 1 to bit 19 of the control word clears it. Writing 0 to bit 19 leaves it unchanged. If both happen in the same cycle, the set wins. With fault-enable 0, a missing acknowledge does not set the fault bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | OFS_W | Byte offset of the word being accessed |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Management data as seen on the line |

## Verification
Two events can fall in the same cycle: the engine finishing a frame, and a bus write arriving at the command word while the start bit is still set. The bench provokes this by writing new command words repeatedly for as long as the busy bit reads 1, so that one of those writes lands in the cycle the frame closes. It judges the result by requiring exactly 64 management clock rises and the first command's fields and result in the word afterwards. The bench then issues a new command in the first cycle the start bit reads clear, and checks that this command is accepted as a normal frame. Randomised reads and writes also set the fault bit and clear it by writing 1, and the fault bit is compared with a model after every transaction.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_POS     = 46;
    localparam int ACK_POS    = 47;
    localparam int DATA_POS   = 48;
    localparam int LAST_POS   = FRAME_BITS - 1;

    localparam int GO_BIT    = 31;
    localparam int WR_BIT    = 30;
    localparam int ACK_BIT   = 29;
    localparam int EN_BIT    = 30;
    localparam int FAULT_BIT = 19;
    localparam int FE_BIT    = 18;

    typedef struct packed {
        logic        go;
        logic        wr;
        logic        ack;
        logic [4:0]  regad;
        logic [4:0]  phyad;
        logic [15:0] data;
    } uacc_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic wr, input logic [4:0] phy, input logic [4:0] regad,
        input logic [15:0] wdata);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, regad,
                (wr ? 2'b10 : 2'b11), (wr ? wdata : 16'hFFFF)};
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } cg_t;

    cg_t s_d, s_q;
    logic [DIV_W-1:0] d_eff;
    logic [DIV_W:0]   half;

    always_comb begin
        d_eff    = (div == '0) ? DIV_W'(1) : div;
        half     = ({1'b0, d_eff} + (DIV_W+1)'(1)) >> 1;
        rise_stb = run && ({1'b0, s_q.cnt} == half - (DIV_W+1)'(1));
        fall_stb = run && (s_q.cnt >= d_eff);
        s_d      = s_q;
        if (!run) begin
            s_d.cnt = '0;
            s_d.mdc = 1'b0;
        end else if (fall_stb) begin
            s_d.cnt = '0;
            s_d.mdc = 1'b0;
        end else begin
            s_d.cnt = s_q.cnt + DIV_W'(1);
            if (rise_stb) s_d.mdc = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc = s_q.mdc;

    // R3: mdc may fall only on a fall strobe or when the clock stops
    a_r3_fall_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc) |-> $past(fall_stb || !run));
    // R3: mdc rises only after a rise strobe
    a_r3_rise_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $past(rise_stb));
endmodule

// File: rtl/mdio_frame.sv
`timescale 1ns/1ps
module mdio_frame
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        wr,
    input  logic [4:0]  phy,
    input  logic [4:0]  regad,
    input  logic [15:0] wdata,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        ack,
    output logic        mdio_o,
    output logic        mdio_oe
);
    typedef struct packed {
        logic                  busy;
        logic                  wr;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] sh;
        logic                  mo;
        logic                  oe;
        logic [15:0]           rx;
        logic                  ack;
        logic                  done;
    } fr_t;

    fr_t s_d, s_q;
    logic [FRAME_BITS-1:0] frame;
    logic [IDX_W-1:0]      idx_nx;

    always_comb begin
        frame  = build_frame(wr, phy, regad, wdata);
        idx_nx = s_q.idx + IDX_W'(1);
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.wr   = wr;
                s_d.idx  = '0;
                s_d.mo   = frame[FRAME_BITS-1];
                s_d.sh   = frame << 1;
                s_d.oe   = 1'b1;
                s_d.rx   = '0;
                s_d.ack  = 1'b0;
            end
        end else begin
            if (rise_stb && !s_q.wr) begin
                if (s_q.idx == IDX_W'(ACK_POS)) s_d.ack = ~mdio_i;
                if (s_q.idx >= IDX_W'(DATA_POS)) s_d.rx = {s_q.rx[14:0], mdio_i};
            end
            if (fall_stb) begin
                if (s_q.idx == IDX_W'(LAST_POS)) begin
                    s_d.busy = 1'b0;
                    s_d.oe   = 1'b0;
                    s_d.mo   = 1'b0;
                    s_d.done = 1'b1;
                end else begin
                    s_d.idx = idx_nx;
                    s_d.mo  = s_q.sh[FRAME_BITS-1];
                    s_d.sh  = s_q.sh << 1;
                    s_d.oe  = s_q.wr || (idx_nx < IDX_W'(TA_POS));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign done    = s_q.done;
    assign rdata   = s_q.rx;
    assign ack     = s_q.ack;
    assign mdio_o  = s_q.mo;
    assign mdio_oe = s_q.oe;

    // R4: the data line only moves at a falling mdc edge or on command accept
    a_r4_mdio_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(fall_stb) && !$past(start)) |-> $stable(mdio_o));
    // R5: the line is released while the PHY owns it during a read
    a_r5_release_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !s_q.wr && rise_stb && s_q.idx >= IDX_W'(TA_POS)) |-> !mdio_oe);
    // R7: rise and fall strobes never coincide while a frame runs
    a_r7_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(rise_stb && fall_stb));
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OFS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFS_W-1:0] bus_addr,
    input  logic             bus_we,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    localparam logic [OFS_W-1:0] CTRL_OFS = OFS_W'(0);
    localparam logic [OFS_W-1:0] USER_OFS = OFS_W'(4);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             en;
        logic             fault_en;
        logic             fault;
        uacc_t            ua;
    } regs_t;

    regs_t r_d, r_q;
    logic sel_ctrl, sel_user, cmd_ok, start;
    logic eng_busy, eng_done, eng_ack, rise_stb, fall_stb, run;
    logic [15:0] eng_rdata;
    logic unused_wbits;

    assign unused_wbits = ^{bus_wdata[28:26], bus_wdata[29:20] & 10'h0, bus_wdata[17:16]};
    assign sel_ctrl = (bus_addr == CTRL_OFS);
    assign sel_user = (bus_addr == USER_OFS);
    assign cmd_ok   = bus_we && sel_user && !r_q.ua.go && r_q.en;
    assign start    = cmd_ok && bus_wdata[GO_BIT];
    assign run      = r_q.en && eng_busy;

    always_comb begin
        r_d = r_q;
        if (bus_we && sel_ctrl) begin
            r_d.div      = bus_wdata[DIV_W-1:0];
            r_d.en       = bus_wdata[EN_BIT];
            r_d.fault_en = bus_wdata[FE_BIT];
            if (bus_wdata[FAULT_BIT]) r_d.fault = 1'b0;
        end
        if (eng_done) begin
            r_d.ua.go = 1'b0;
            if (!r_q.ua.wr) begin
                r_d.ua.data = eng_rdata;
                r_d.ua.ack  = eng_ack;
                if (!eng_ack && r_q.fault_en) r_d.fault = 1'b1;
            end
        end
        if (cmd_ok) begin
            r_d.ua.go    = bus_wdata[GO_BIT];
            r_d.ua.wr    = bus_wdata[WR_BIT];
            r_d.ua.ack   = 1'b0;
            r_d.ua.regad = bus_wdata[25:21];
            r_d.ua.phyad = bus_wdata[20:16];
            r_d.ua.data  = bus_wdata[15:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata[DIV_W-1:0] = r_q.div;
            bus_rdata[FE_BIT]    = r_q.fault_en;
            bus_rdata[FAULT_BIT] = r_q.fault;
            bus_rdata[EN_BIT]    = r_q.en;
            bus_rdata[GO_BIT]    = r_q.ua.go;
        end else if (sel_user) begin
            bus_rdata[GO_BIT]  = r_q.ua.go;
            bus_rdata[WR_BIT]  = r_q.ua.wr;
            bus_rdata[ACK_BIT] = r_q.ua.ack;
            bus_rdata[25:21]   = r_q.ua.regad;
            bus_rdata[20:16]   = r_q.ua.phyad;
            bus_rdata[15:0]    = r_q.ua.data;
        end
    end

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(run), .div(r_q.div),
        .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_frame u_frame (
        .clk(clk), .rst_n(rst_n), .start(start),
        .wr(bus_wdata[WR_BIT]), .phy(bus_wdata[20:16]), .regad(bus_wdata[25:21]),
        .wdata(bus_wdata[15:0]), .rise_stb(rise_stb), .fall_stb(fall_stb),
        .mdio_i(mdio_i), .busy(eng_busy), .done(eng_done), .rdata(eng_rdata),
        .ack(eng_ack), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // R7: the start bit drops right after the engine reports the end of a frame
    a_r7_go_clears: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !r_q.ua.go);
    // R8: a command write during a running frame leaves the fields untouched
    a_r8_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ua.go && bus_we && sel_user && !eng_done) |=>
            ($stable(r_q.ua.phyad) && $stable(r_q.ua.regad) && $stable(r_q.ua.wr)));
    // R9: no command is taken while the block is disabled
    a_r9_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.en && !r_q.ua.go && bus_we && sel_user) |=> !r_q.ua.go);
    // R10: fault is only raised by a finished read while fault-enable is set
    a_r10_fault_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.fault) |-> $past(eng_done && r_q.fault_en));
endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int total = 0;
    int bad = 0;

    logic [63:0] cap_o, cap_oe;
    int          rise_cnt = 0;
    int          per_bad = 0;
    int          exp_per = 2;
    time         last_t = 0;
    logic        resp_ack = 1'b1;
    logic [15:0] resp_data = '0;
    logic        m_fault = 1'b0;

    always #4 clk = ~clk;

    mdio_master u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: records each bit at a rising mdc, then prepares the next one
    always @(posedge mdc) begin
        int bitn;
        int nx;
        bitn = rise_cnt % 64;
        cap_o[63-bitn]  = mdio_o;
        cap_oe[63-bitn] = mdio_oe;
        if (bitn != 0 && ($time - last_t) != time'(exp_per * 8)) per_bad++;
        last_t = $time;
        rise_cnt++;
        #1;
        nx = (bitn + 1) % 64;
        if (nx == 47)      mdio_i = resp_ack ? 1'b0 : 1'b1;
        else if (nx >= 48) mdio_i = resp_data[63-nx];
        else               mdio_i = 1'b1;
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl_val(input logic busy, input logic en,
        input logic fault, input logic fe, input logic [15:0] div);
        return {busy, en, 10'b0, fault, fe, 2'b0, div};
    endfunction

    function automatic logic [31:0] user_val(input logic go, input logic wr,
        input logic ack, input logic [4:0] ra, input logic [4:0] pa, input logic [15:0] d);
        return {go, wr, ack, 3'b0, ra, pa, d};
    endfunction

    function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] pa,
        input logic [4:0] ra, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), pa, ra, 2'b10, d};
    endfunction

    function automatic logic [63:0] exp_oe(input logic wr);
        return wr ? 64'hFFFF_FFFF_FFFF_FFFF : {46'h3FFF_FFFF_FFFF, 18'h0};
    endfunction

    task automatic wr32(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd32(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 4000; i++) begin
            rd32(4'd4, v);
            if (!v[31]) return;
        end
        check("R7 start bit never cleared", 64'd1, 64'd0);
    endtask

    task automatic txn(input logic wr, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] d, input logic ack, input logic fe);
        logic [31:0] v;
        logic [63:0] ef, eo;
        int r0;
        resp_ack = ack;
        resp_data = $urandom();
        r0 = rise_cnt;
        per_bad = 0;
        wr32(4'd4, user_val(1'b1, wr, 1'b0, ra, pa, d));
        rd32(4'd0, v);
        check("R7 busy bit in control word", 64'(v[31]), 64'd1);
        wait_idle();
        ef = exp_frame(wr, pa, ra, d);
        eo = exp_oe(wr);
        check(wr ? "R4 write output enable" : "R5 read output enable", cap_oe, eo);
        check(wr ? "R4 write frame bits" : "R5 read frame bits", cap_o & eo, ef & eo);
        check("R7 one frame per command", 64'(rise_cnt - r0), 64'd64);
        check("R3 mdc period", 64'(per_bad), 64'd0);
        rd32(4'd4, v);
        if (wr) check("R6 R7 word after write", 64'(v), 64'(user_val(0, 1, 0, ra, pa, d)));
        else    check("R6 word after read", 64'(v), 64'(user_val(0, 0, ack, ra, pa, resp_data)));
        if (!wr && !ack && fe) m_fault = 1'b1;
        check("R3 mdc low after frame", 64'(mdc), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [15:0] div;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd32(4'd0, v); check("R1 control reset", 64'(v), 64'd0);
        rd32(4'd4, v); check("R1 command reset", 64'(v), 64'd0);
        check("R1 mdc and oe at reset", {62'd0, mdc, mdio_oe}, 64'd0);

        // R9 disabled: command ignored
        wr32(4'd4, user_val(1, 1, 0, 5'd3, 5'd7, 16'h1234));
        repeat (60) @(negedge clk);
        rd32(4'd4, v); check("R9 command ignored while disabled", 64'(v), 64'd0);
        check("R9 no mdc while disabled", 64'(rise_cnt), 64'd0);

        // R2 control readback
        wr32(4'd0, ctrl_val(0, 1, 0, 1, 16'd3));
        rd32(4'd0, v); check("R2 control readback", 64'(v), 64'(ctrl_val(0, 1, 0, 1, 16'd3)));
        exp_per = 4;

        // directed: write, read with ack, read without ack (R10 set)
        txn(1'b1, 5'h1F, 5'h00, 16'hA5C3, 1'b1, 1'b1);
        txn(1'b0, 5'h00, 5'h1F, 16'h0000, 1'b1, 1'b1);
        txn(1'b0, 5'h15, 5'h0A, 16'h0000, 1'b0, 1'b1);
        rd32(4'd0, v); check("R10 fault set by missing ack", 64'(v[19]), 64'd1);
        wr32(4'd0, ctrl_val(0, 1, 0, 1, 16'd3));
        rd32(4'd0, v); check("R10 writing 0 keeps fault", 64'(v[19]), 64'd1);
        wr32(4'd0, ctrl_val(0, 1, 1, 1, 16'd3));
        rd32(4'd0, v); check("R10 writing 1 clears fault", 64'(v[19]), 64'd0);
        m_fault = 1'b0;

        // R10 fault-enable off: no fault
        wr32(4'd0, ctrl_val(0, 1, 0, 0, 16'd3));
        txn(1'b0, 5'h02, 5'h04, 16'h0, 1'b0, 1'b0);
        rd32(4'd0, v); check("R10 no fault when disabled", 64'(v[19]), 64'd0);

        // R3 divider 0 acts as 1
        wr32(4'd0, ctrl_val(0, 1, 0, 1, 16'd0));
        exp_per = 2;
        txn(1'b1, 5'h09, 5'h11, 16'hFFFF, 1'b1, 1'b1);

        // R8 hammer writes during a frame, including its final cycle
        begin
            int r0;
            resp_ack = 1'b1;
            r0 = rise_cnt;
            wr32(4'd4, user_val(1, 1, 0, 5'h06, 5'h0C, 16'h5A5A));
            for (int i = 0; i < 2000; i++) begin
                wr32(4'd4, user_val(1, 0, 0, 5'h1B, 5'h13, 16'h0F0F));
                rd32(4'd4, v);
                if (!v[31]) break;
            end
            check("R8 single frame under write storm", 64'(rise_cnt - r0), 64'd64);
            check("R8 fields kept under write storm", 64'(v), 64'(user_val(0, 1, 0, 5'h06, 5'h0C, 16'h5A5A)));
            // immediate reissue in the first idle cycle
            txn(1'b0, 5'h0E, 5'h03, 16'h0, 1'b1, 1'b1);
        end

        // randomised transactions with fault model
        for (int k = 0; k < 24; k++) begin
            logic w, a;
            div = 16'($urandom_range(0, 6));
            exp_per = (div == 0) ? 2 : int'(div) + 1;
            wr32(4'd0, ctrl_val(0, 1, 0, 1, div));
            w = 1'($urandom());
            a = ($urandom_range(0, 3) != 0);
            txn(w, 5'($urandom()), 5'($urandom()), 16'($urandom()), a, 1'b1);
            rd32(4'd0, v);
            check("R2 R10 control after random frame", 64'(v), 64'(ctrl_val(0, 1, m_fault, 1, div)));
            if (m_fault && $urandom_range(0, 1) == 1) begin
                wr32(4'd0, ctrl_val(0, 1, 1, 1, div));
                m_fault = 1'b0;
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule